// File: doc/BRIEF.md
# Auto-Reload Compare Timer

A single-channel up-counter that compares its running count against a programmable value and raises a sticky interrupt flag whenever the two are equal while the timer is running. The counter is `W` bits wide (18 by default). Three behaviours follow a match, chosen by a mode field: the timer can halt (one-shot), return to zero and keep going (interval), or simply continue counting through its whole range and wrap (free-run).

Software controls the block through a small write-only register port with four addresses: compare value, mode, command (start/stop) and interrupt status. The status is cleared by writing a one to it. The count is always visible on an output port, and the interrupt line is the status flag itself.

Top module: `cmp_reload_timer`

## Requirements
- R1: While `rst` is high, at the following edge the count is 0, the timer is stopped and `irq_o` is 0.
- R2: A write to address 2 with bit 0 set starts the timer: the count is 0 after that edge, and each later edge while running and not matching adds one.
- R3: A write to address 2 with bit 1 set and bit 0 clear stops the timer and leaves the count unchanged; when both bits are set, start wins.
- R4: At every edge where the timer is running and the count equals the compare value (address 0), the status flag is set after that edge.
- R5: In one-shot mode (address 1 value 0) a match stops the timer and the count stays at the compare value.
- R6: In interval mode (address 1 value 1) a match returns the count to 0 and the timer keeps running, so the count repeats every compare+1 edges.
- R7: In free-run mode (address 1 value 2, and value 3 behaves the same) a match does not disturb counting; the count runs up to 2^W-1 and wraps to 0.
- R8: The status flag stays set until a write to address 3 with bit 0 set; a write with bit 0 clear leaves it unchanged.
- R9: A match at the same edge as a status clear leaves the flag set.
- R10: In interval mode with a compare value of 0, the count stays at 0 and a match occurs on every edge.
- R11: While stopped the count does not move and no match is raised, even when the count equals the compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 compare, 1 mode, 2 command, 3 status |
| wr_data | input | W | Write data |
| count_o | output | W | Current count |
| irq_o | output | 1 | Interrupt, equal to the sticky status flag |

## Verification
The checker watches every cycle for the local rules: single-step increments, the reload to zero in interval mode, the halt in one-shot mode, freezing on stop and while idle, the flag being set on a match and holding until cleared. What only the bench scenarios show is the behaviour over whole runs: the count sequence and repetition period for each mode and several compare values, the wrap at the top of the range in free-run, the first-match latency of the interrupt, and the ordering of clear, stop and match in directed sequences.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;

    localparam int unsigned ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_COMPARE = 2'd0;
    localparam logic [ADDR_W-1:0] A_MODE    = 2'd1;
    localparam logic [ADDR_W-1:0] A_CMD     = 2'd2;
    localparam logic [ADDR_W-1:0] A_STATUS  = 2'd3;

    localparam int unsigned CMD_GO_BIT   = 0;
    localparam int unsigned CMD_HALT_BIT = 1;
    localparam int unsigned CLR_BIT      = 0;

    typedef enum logic [1:0] {
        MODE_ONESHOT  = 2'd0,
        MODE_INTERVAL = 2'd1,
        MODE_FREERUN  = 2'd2,
        MODE_FREEALT  = 2'd3
    } tmr_mode_e;

    typedef enum logic [1:0] {
        ACT_ADVANCE,
        ACT_RELOAD,
        ACT_HALT
    } match_act_e;

    typedef struct packed {
        logic go;
        logic halt;
        logic clear;
    } tmr_cmd_t;

    function automatic match_act_e act_on_match(input tmr_mode_e m);
        case (m)
            MODE_ONESHOT:  return ACT_HALT;
            MODE_INTERVAL: return ACT_RELOAD;
            default:       return ACT_ADVANCE;
        endcase
    endfunction

    function automatic logic is_cmd_write(input logic en, input logic [ADDR_W-1:0] a,
                                          input logic go_b, input logic halt_b);
        return en && (a == A_CMD) && (go_b || halt_b);
    endfunction

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import cmp_timer_pkg::*;
#(
    parameter int unsigned W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    output logic [W-1:0]      cmp_q,
    output tmr_mode_e         mode_q,
    output tmr_cmd_t          cmd
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q  <= '0;
            mode_q <= MODE_ONESHOT;
        end else if (wr_en) begin
            if (wr_addr == A_COMPARE) cmp_q  <= wr_data;
            if (wr_addr == A_MODE)    mode_q <= tmr_mode_e'(wr_data[1:0]);
        end
    end

    always_comb begin
        cmd       = '0;
        cmd.go    = wr_en && (wr_addr == A_CMD) && wr_data[CMD_GO_BIT];
        cmd.halt  = wr_en && (wr_addr == A_CMD) && wr_data[CMD_HALT_BIT];
        cmd.clear = wr_en && (wr_addr == A_STATUS) && wr_data[CLR_BIT];
    end

endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import cmp_timer_pkg::*;
#(
    parameter int unsigned W = 18
) (
    input  logic         clk,
    input  logic         rst,
    input  tmr_cmd_t     cmd,
    input  logic [W-1:0] cmp,
    input  tmr_mode_e    mode,
    output logic [W-1:0] count_q,
    output logic         run_q,
    output logic         hit
);

    localparam logic [W-1:0] STEP = W'(1);

    match_act_e act;

    always_comb begin
        hit = run_q && (count_q == cmp);
        act = act_on_match(mode);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            run_q   <= 1'b0;
        end else if (cmd.go) begin
            count_q <= '0;
            run_q   <= 1'b1;
        end else if (cmd.halt) begin
            run_q   <= 1'b0;
        end else if (run_q) begin
            if (hit) begin
                case (act)
                    ACT_HALT:   run_q   <= 1'b0;
                    ACT_RELOAD: count_q <= '0;
                    default:    count_q <= count_q + STEP;
                endcase
            end else begin
                count_q <= count_q + STEP;
            end
        end
    end

endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
    input  logic clk,
    input  logic rst,
    input  logic hit,
    input  logic clear,
    output logic flag_q
);

    always_ff @(posedge clk) begin
        if (rst)        flag_q <= 1'b0;
        else if (hit)   flag_q <= 1'b1;
        else if (clear) flag_q <= 1'b0;
    end

endmodule

// File: rtl/cmp_reload_timer.sv
module cmp_reload_timer
    import cmp_timer_pkg::*;
#(
    parameter int unsigned W = 18
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [1:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] count_o,
    output logic         irq_o
);

    logic [W-1:0] cmp_w;
    tmr_mode_e    mode_w;
    tmr_cmd_t     cmd_w;
    logic         run_w;
    logic         hit_w;

    tmr_regs #(.W(W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cmp_q   (cmp_w),
        .mode_q  (mode_w),
        .cmd     (cmd_w)
    );

    tmr_core #(.W(W)) u_core (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd_w),
        .cmp     (cmp_w),
        .mode    (mode_w),
        .count_q (count_o),
        .run_q   (run_w),
        .hit     (hit_w)
    );

    tmr_flag u_flag (
        .clk    (clk),
        .rst    (rst),
        .hit    (hit_w),
        .clear  (cmd_w.clear),
        .flag_q (irq_o)
    );

endmodule

// File: rtl/cmp_reload_timer_chk.sv
module cmp_reload_timer_chk
    import cmp_timer_pkg::*;
#(
    parameter int unsigned W = 18
) (
    input logic         clk,
    input logic         rst,
    input logic         wr_en,
    input logic [1:0]   wr_addr,
    input logic [W-1:0] wr_data,
    input logic [W-1:0] count_o,
    input logic         irq_o,
    input logic         running,
    input logic [W-1:0] cmp,
    input tmr_mode_e    mode
);

    localparam logic [W-1:0] ONE = W'(1);

    logic cmd_any, go_wr, halt_only, clr_wr, match;
    always_comb begin
        cmd_any   = is_cmd_write(wr_en, wr_addr, wr_data[CMD_GO_BIT], wr_data[CMD_HALT_BIT]);
        go_wr     = wr_en && (wr_addr == A_CMD) && wr_data[CMD_GO_BIT];
        halt_only = wr_en && (wr_addr == A_CMD) && wr_data[CMD_HALT_BIT] && !wr_data[CMD_GO_BIT];
        clr_wr    = wr_en && (wr_addr == A_STATUS) && wr_data[CLR_BIT];
        match     = running && (count_o == cmp);
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (count_o == '0) && !irq_o && !running);

    p_start_zero_r2: assert property (@(posedge clk) disable iff (rst)
        go_wr |=> (count_o == '0) && running);

    p_step_up_r2: assert property (@(posedge clk) disable iff (rst)
        running && !match && !cmd_any |=> count_o == $past(count_o) + ONE);

    p_stop_freeze_r3: assert property (@(posedge clk) disable iff (rst)
        halt_only |=> !running && (count_o == $past(count_o)));

    p_match_sets_r4: assert property (@(posedge clk) disable iff (rst)
        match |=> irq_o);

    p_oneshot_halt_r5: assert property (@(posedge clk) disable iff (rst)
        match && (mode == MODE_ONESHOT) && !cmd_any |=> !running && (count_o == $past(cmp)));

    p_interval_reload_r6: assert property (@(posedge clk) disable iff (rst)
        match && (mode == MODE_INTERVAL) && !cmd_any |=> running && (count_o == '0));

    p_freerun_step_r7: assert property (@(posedge clk) disable iff (rst)
        match && mode[1] && !cmd_any |=> running && (count_o == $past(count_o) + ONE));

    p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        irq_o && !clr_wr |=> irq_o);

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !running && !cmd_any |=> $stable(count_o) && !running);

    p_idle_no_set_r11: assert property (@(posedge clk) disable iff (rst)
        !running && !irq_o |=> !irq_o);

endmodule

bind cmp_reload_timer cmp_reload_timer_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .count_o (count_o),
    .irq_o   (irq_o),
    .running (run_w),
    .cmp     (cmp_w),
    .mode    (mode_w)
);

// File: tb/sim_cmp_reload_timer.sv
module sim_cmp_reload_timer;

    localparam int TW = 10;
    localparam int CLK_PERIOD = 10;
    localparam int RANGE = 1 << TW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [TW-1:0] wr_data = '0;
    logic [TW-1:0] count_o;
    logic          irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmp_reload_timer #(.W(TW)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .count_o(count_o), .irq_o(irq_o)
    );

    task automatic check(input string tag, input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d at %0t", tag, what, got, exp, $time);
        end
    endtask

    task automatic wr(input logic [1:0] a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = TW'(d);
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic step(input int k);
        for (int i = 0; i < k; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    // Stop, clear, configure, start; then compare a whole run with arithmetic.
    task automatic sweep(input int mode, input int cmpv, input int steps, input string tag);
        int exp_c;
        wr(2'd2, 2);
        wr(2'd3, 1);
        wr(2'd1, mode);
        wr(2'd0, cmpv);
        wr(2'd2, 1);
        for (int n = 0; n <= steps; n++) begin
            if (mode == 0)      exp_c = (n < cmpv) ? n : cmpv;
            else if (mode == 1) exp_c = n % (cmpv + 1);
            else                exp_c = n % RANGE;
            check(tag, "count", int'(count_o), exp_c);
            check("R4", "irq", int'(irq_o), (n > cmpv) ? 1 : 0);
            step(1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        step(3);
        check("R1", "count after reset", int'(count_o), 0);
        check("R1", "irq after reset", int'(irq_o), 0);
        @(negedge clk); rst = 1'b0;
        step(4);
        check("R1", "idle count", int'(count_o), 0);

        // R5 one-shot, R6/R10 interval, R7 free-run
        sweep(0, 0, 5, "R5");
        sweep(0, 1, 6, "R5");
        sweep(0, 4, 10, "R5");
        sweep(0, 9, 15, "R5");
        sweep(1, 0, 6, "R10");
        sweep(1, 1, 8, "R6");
        sweep(1, 3, 14, "R6");
        sweep(1, 7, 26, "R6");
        sweep(2, 5, RANGE + 8, "R7");
        sweep(2, RANGE - 1, RANGE + 3, "R7");
        sweep(3, 2, 20, "R7");

        // R8 / R11: one-shot parked on its match value
        sweep(0, 3, 6, "R5");
        wr(2'd3, 0);
        check("R8", "irq after zero write", int'(irq_o), 1);
        wr(2'd3, 1);
        check("R8", "irq after clear", int'(irq_o), 0);
        step(4);
        check("R11", "irq while parked", int'(irq_o), 0);
        check("R11", "count while parked", int'(count_o), 3);

        // R9: match on every edge in interval mode with compare 0
        sweep(1, 0, 2, "R10");
        wr(2'd3, 1);
        check("R9", "irq on clear vs match", int'(irq_o), 1);
        wr(2'd2, 2);
        wr(2'd3, 1);
        check("R8", "irq after clear when stopped", int'(irq_o), 0);
        step(3);
        check("R11", "no match while stopped", int'(irq_o), 0);

        // R3: stop freezes, start wins over stop
        sweep(2, RANGE - 1, 7, "R2");
        wr(2'd2, 2);
        check("R3", "count at stop", int'(count_o), 8);
        step(5);
        check("R3", "count frozen", int'(count_o), 8);
        wr(2'd2, 3);
        check("R3", "start wins", int'(count_o), 0);
        step(1);
        check("R2", "counts after restart", int'(count_o), 1);

        finish_run();
    end

endmodule